// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one management transaction at a time on a two-wire PHY management bus: a clock line (MDC) that it generates itself, and a shared bidirectional data line whose output value and output enable it drives, and whose input it samples. A command is issued with a one-cycle start pulse. The pulse carries a read/write flag, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a quarter-period length. The block then produces a complete frame: a run of ones, a 14-bit header, a turnaround and a 16-bit data field. The frame ends with one released clock. Completion is reported with a one-cycle done pulse, and for a read the sampled register value is returned on the result bus.

Each MDC bit period has four equal quarters: low, high, high, low. Each quarter lasts a number of system clocks taken from the command when it is accepted. Bits that the block drives change only at the start of the first (low) quarter. Bits that the PHY drives are sampled on the last system clock of the second quarter, while MDC is high. The output enable is low whenever the PHY owns the line, so the pad can release it.

Top module: `mdio_frame_master`

## Requirements
- R1: During reset and while idle, `mdc`, `mdio_oe`, `cmd_busy` and `cmd_done` are low. After reset, `cmd_rdata` is zero.
- R2: A bit period is 4·L system clocks, where L is `quarter_len` latched at the accepted start and a value of 0 counts as 1. MDC is low for the first L clocks, high for the next 2·L and low for the last L. Driven bits stay stable while MDC is high.
- R3: A frame opens with PRE_LEN (default 32) bits driven to 1 with `mdio_oe` high.
- R4: Next come 14 header bits, sent MSB first with `mdio_oe` high. They are the start code 0,1, then the opcode (read = 1,0, write = 0,1), then PHY address bits 4..0, then register address bits 4..0.
- R5: On a write, the header is followed by a driven 1 and then a driven 0, then write data bits 15..0.
- R6: On a read, `mdio_oe` is low for one turnaround bit after the header and then for 16 data bits. `mdio_in` is sampled once per data bit, on the last clock of its second quarter. The first sampled bit ends up in `cmd_rdata[15]` and the last in `cmd_rdata[0]`.
- R7: After the data field, each frame has one more bit with `mdio_oe` low. A read therefore lasts PRE_LEN+32 bits and a write PRE_LEN+33 bits.
- R8: `cmd_done` is high for exactly one system clock, starting N·4·L clocks after the edge that accepted the start, where N is the bit count. `cmd_busy` is high from the clock after acceptance up to that point and falls together with the rise of `cmd_done`.
- R9: A start pulse while `cmd_busy` is high is ignored. Command inputs that change after acceptance have no effect on the running frame.
- R10: `cmd_rdata` holds its value from `cmd_done` until the next accepted start. A write frame never changes it.
- R11: A start pulse in the same clock as `cmd_done` is accepted, and the next frame follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle command request |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| quarter_len | input | DIV_W | System clocks per MDC quarter period (0 treated as 1) |
| cmd_busy | output | 1 | Frame in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input |

## Verification
The completion pulse and the acceptance of the next command can fall in the same clock, because busy has already dropped when done is raised. The bench provokes this by asserting a new start in the done cycle of a read. It then expects the write frame to open on the next clock, with busy never low for a full idle clock, while the read result stays on the result bus. A second collision comes from injecting a start with scrambled fields partway through a frame. That pulse must leave every bit of the running frame and its completion time unchanged. The bench also drives the complement of the neighbouring data bits during the turnaround and trailing bits, so a sample taken one bit early or late would show up in the result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int unsigned HDR_BITS   = 14;
   localparam int unsigned DATA_BITS  = 16;
   localparam int unsigned WORD_BITS  = 32;

   typedef enum logic [1:0] {
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10
   } mdio_opc_e;

   // Header, write turnaround and data packed as one word, sent MSB first
   function automatic logic [WORD_BITS-1:0] pack_frame(
      input logic        rd,
      input logic [4:0]  phy,
      input logic [4:0]  rg,
      input logic [15:0] wd
   );
      mdio_opc_e opc;
      opc = rd ? OPC_READ : OPC_WRITE;
      return {2'b01, opc, phy, rg, 2'b10, wd};
   endfunction

endpackage

// File: rtl/mdio_quarter_timer.sv
module mdio_quarter_timer #(
   parameter int DIV_W    = 8,
   parameter bit MDC_FLOP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] qlen,
   output logic             mdc,
   output logic             sample_stb,
   output logic             bit_end
);

   logic [DIV_W-1:0] qcnt;
   logic [1:0]       phase;
   logic [1:0]       phase_nxt;
   logic             last_q;

   assign last_q = run && (qcnt == qlen - DIV_W'(1));

   always_comb begin
      phase_nxt = phase;
      if (restart || !run)
         phase_nxt = 2'd0;
      else if (last_q)
         phase_nxt = phase + 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qcnt  <= '0;
         phase <= 2'd0;
      end else begin
         phase <= phase_nxt;
         if (restart || !run || last_q)
            qcnt <= '0;
         else
            qcnt <= qcnt + DIV_W'(1);
      end
   end

   assign sample_stb = last_q && (phase == 2'd1);
   assign bit_end    = last_q && (phase == 2'd3);

   generate
      if (MDC_FLOP) begin : g_mdc_flop
         logic mdc_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               mdc_q <= 1'b0;
            else
               mdc_q <= (phase_nxt == 2'd1) || (phase_nxt == 2'd2);
         end
         assign mdc = mdc_q;
      end else begin : g_mdc_decode
         assign mdc = (phase == 2'd1) || (phase == 2'd2);
      end
   endgenerate

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          din,
   output logic [DW-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (shift_en)
         rdata <= {rdata[DW-2:0], din};
   end

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int DIV_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_start,
   input  logic                 cmd_read,
   input  logic [4:0]           cmd_phy,
   input  logic [4:0]           cmd_reg,
   input  logic [15:0]          cmd_wdata,
   input  logic [DIV_W-1:0]     quarter_len,
   input  logic                 bit_end,
   input  logic                 sample_stb,
   output logic                 busy,
   output logic                 done,
   output logic                 accept,
   output logic                 cap_en,
   output logic                 drv_val,
   output logic                 drv_oe,
   output logic                 frm_read,
   output logic [WORD_BITS-1:0] frm_word,
   output logic [DIV_W-1:0]     frm_qlen
);

   localparam int IDX_W    = $clog2(PRE_LEN + 34);
   localparam int HDR_END  = PRE_LEN + HDR_BITS;
   localparam int WR_END   = PRE_LEN + WORD_BITS;
   localparam int RD_LO    = PRE_LEN + HDR_BITS + 1;
   localparam int RD_HI    = RD_LO + DATA_BITS - 1;
   localparam int RD_LAST  = RD_HI + 1;
   localparam int WR_LAST  = WR_END;

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] nxt_idx;
   logic [IDX_W-1:0] last_idx;
   logic [4:0]       tx_sel;
   logic             nxt_val;
   logic             nxt_oe;

   assign accept   = cmd_start && !busy;
   assign nxt_idx  = idx + IDX_W'(1);
   assign last_idx = frm_read ? IDX_W'(RD_LAST) : IDX_W'(WR_LAST);
   assign tx_sel   = 5'(nxt_idx - IDX_W'(PRE_LEN));

   always_comb begin
      nxt_val = 1'b0;
      nxt_oe  = 1'b0;
      if (nxt_idx < IDX_W'(PRE_LEN)) begin
         nxt_val = 1'b1;
         nxt_oe  = 1'b1;
      end else if ((nxt_idx < IDX_W'(HDR_END)) ||
                   (!frm_read && (nxt_idx < IDX_W'(WR_END)))) begin
         nxt_val = frm_word[5'd31 - tx_sel];
         nxt_oe  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         idx      <= '0;
         drv_val  <= 1'b0;
         drv_oe   <= 1'b0;
         frm_read <= 1'b0;
         frm_word <= '0;
         frm_qlen <= DIV_W'(1);
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            idx      <= '0;
            drv_val  <= 1'b1;
            drv_oe   <= 1'b1;
            frm_read <= cmd_read;
            frm_word <= pack_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
            frm_qlen <= (quarter_len == '0) ? DIV_W'(1) : quarter_len;
         end else if (busy && bit_end) begin
            if (idx == last_idx) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               drv_val <= 1'b0;
               drv_oe  <= 1'b0;
            end else begin
               idx     <= nxt_idx;
               drv_val <= nxt_val;
               drv_oe  <= nxt_oe;
            end
         end
      end
   end

   assign cap_en = busy && frm_read && sample_stb &&
                   (idx >= IDX_W'(RD_LO)) && (idx <= IDX_W'(RD_HI));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_pkg::*;
#(
   parameter int PRE_LEN  = 32,
   parameter int DIV_W    = 8,
   parameter bit MDC_FLOP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic             cmd_read,
   input  logic [4:0]       cmd_phy,
   input  logic [4:0]       cmd_reg,
   input  logic [15:0]      cmd_wdata,
   input  logic [DIV_W-1:0] quarter_len,
   output logic             cmd_busy,
   output logic             cmd_done,
   output logic [15:0]      cmd_rdata,
   output logic             mdc,
   output logic             mdio_out,
   output logic             mdio_oe,
   input  logic             mdio_in
);

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("mdio_frame_master: PRE_LEN must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("mdio_frame_master: DIV_W must be at least 1");
      end
   endgenerate

   logic                 accept;
   logic                 cap_en;
   logic                 bit_end;
   logic                 sample_stb;
   logic                 frm_read;
   logic [WORD_BITS-1:0] frm_word;
   logic [DIV_W-1:0]     frm_qlen;

   mdio_frame_ctrl #(
      .PRE_LEN (PRE_LEN),
      .DIV_W   (DIV_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_read    (cmd_read),
      .cmd_phy     (cmd_phy),
      .cmd_reg     (cmd_reg),
      .cmd_wdata   (cmd_wdata),
      .quarter_len (quarter_len),
      .bit_end     (bit_end),
      .sample_stb  (sample_stb),
      .busy        (cmd_busy),
      .done        (cmd_done),
      .accept      (accept),
      .cap_en      (cap_en),
      .drv_val     (mdio_out),
      .drv_oe      (mdio_oe),
      .frm_read    (frm_read),
      .frm_word    (frm_word),
      .frm_qlen    (frm_qlen)
   );

   mdio_quarter_timer #(
      .DIV_W    (DIV_W),
      .MDC_FLOP (MDC_FLOP)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (cmd_busy),
      .restart    (accept),
      .qlen       (frm_qlen),
      .mdc        (mdc),
      .sample_stb (sample_stb),
      .bit_end    (bit_end)
   );

   mdio_rx_capture #(
      .DW (DATA_BITS)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cap_en),
      .din      (mdio_in),
      .rdata    (cmd_rdata)
   );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             mdc,
   input logic             mdio_oe,
   input logic             mdio_out,
   input logic [15:0]      rdata,
   input logic             frm_read,
   input logic [31:0]      frm_word,
   input logic [DIV_W-1:0] frm_qlen
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe)); // R1

   AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_oe) && $stable(mdio_out))); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8

   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8

   AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(frm_word) && $stable(frm_read) && $stable(frm_qlen))); // R9

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(rdata)); // R10

endmodule

bind mdio_frame_master mdio_frame_master_chk #(
   .DIV_W (DIV_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (cmd_busy),
   .done     (cmd_done),
   .mdc      (mdc),
   .mdio_oe  (mdio_oe),
   .mdio_out (mdio_out),
   .rdata    (cmd_rdata),
   .frm_read (frm_read),
   .frm_word (frm_word),
   .frm_qlen (frm_qlen)
);

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;

   localparam int PRE = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_start;
   logic        cmd_read;
   logic [4:0]  cmd_phy;
   logic [4:0]  cmd_reg;
   logic [15:0] cmd_wdata;
   logic [7:0]  quarter_len;
   logic        cmd_busy;
   logic        cmd_done;
   logic [15:0] cmd_rdata;
   logic        mdc;
   logic        mdio_out;
   logic        mdio_oe;
   logic        mdio_in;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;
   logic [15:0] exp_rdata = 16'h0000;

   always #2 clk = ~clk;

   mdio_frame_master u_mdio_frame_master (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_read    (cmd_read),
      .cmd_phy     (cmd_phy),
      .cmd_reg     (cmd_reg),
      .cmd_wdata   (cmd_wdata),
      .quarter_len (quarter_len),
      .cmd_busy    (cmd_busy),
      .cmd_done    (cmd_done),
      .cmd_rdata   (cmd_rdata),
      .mdc         (mdc),
      .mdio_out    (mdio_out),
      .mdio_oe     (mdio_oe),
      .mdio_in     (mdio_in)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string region_tag(input int i, input logic rd);
      if (i < PRE)          return "R3";
      if (i < PRE + 14)     return "R4";
      if (rd && i < PRE+31) return "R6";
      if (!rd && i < PRE+32) return "R5";
      return "R7";
   endfunction

   // Per-bit expected drive, from the frame format in the requirements
   task automatic exp_drive(input int i, input logic rd, input logic [31:0] w,
                            output logic oe, output logic v);
      oe = 1'b0;
      v  = 1'b0;
      if (i < PRE) begin
         oe = 1'b1;
         v  = 1'b1;
      end else if (i < PRE + 14 || (!rd && i < PRE + 32)) begin
         oe = 1'b1;
         v  = w[31 - (i - PRE)];
      end
   endtask

   task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [7:0] ql,
                            input logic [15:0] rsp, input int poke_bit, input string extra);
      int          len;
      int          nbits;
      int          ph;
      logic [31:0] w;
      logic        eo;
      logic        ev;
      string       tag;
      len   = (ql == 8'd0) ? 1 : int'(ql);
      nbits = rd ? PRE + 32 : PRE + 33;
      w     = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
      cmd_read    = rd;
      cmd_phy     = phy;
      cmd_reg     = rg;
      cmd_wdata   = wd;
      quarter_len = ql;
      cmd_start   = 1'b1;
      @(posedge clk);
      for (int i = 0; i < nbits; i++) begin
         for (int c = 0; c < 4 * len; c++) begin
            @(negedge clk);
            if (i == 0 && c == 0) begin
               cmd_start   = 1'b0;
               cmd_read    = ~rd;
               cmd_phy     = ~phy;
               cmd_reg     = ~rg;
               cmd_wdata   = ~wd;
               quarter_len = ql + 8'd3;
            end
            if (i == poke_bit && c == 0) cmd_start = 1'b1;
            if (i == poke_bit && c == 1) cmd_start = 1'b0;
            if (c == 0) begin
               if (rd && i >= PRE + 15 && i <= PRE + 30) mdio_in = rsp[15 - (i - PRE - 15)];
               else if (i == PRE + 14)                   mdio_in = ~rsp[15];
               else if (rd && i == PRE + 31)             mdio_in = ~rsp[0];
               else                                      mdio_in = 1'b1;
            end
            ph  = c / len;
            tag = {region_tag(i, rd), extra};
            check({"R2", extra, " mdc"}, 32'(mdc), 32'((ph == 1) || (ph == 2)));
            exp_drive(i, rd, w, eo, ev);
            check({tag, " oe"}, 32'(mdio_oe), 32'(eo));
            if (eo) check({tag, " out"}, 32'(mdio_out), 32'(ev));
            check({"R8", extra, " busy"}, 32'(cmd_busy), 32'd1);
            check({"R8", extra, " done early"}, 32'(cmd_done), 32'd0);
         end
      end
      @(negedge clk);
      if (rd) exp_rdata = rsp;
      check({"R8", extra, " done"}, 32'(cmd_done), 32'd1);
      check({"R8", extra, " busy at done"}, 32'(cmd_busy), 32'd0);
      check({rd ? "R6" : "R10", extra, " rdata"}, 32'(cmd_rdata), 32'(exp_rdata));
   endtask

   task automatic idle_check(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check("R8 done pulse width", 32'(cmd_done), 32'd0);
         check("R1 idle busy", 32'(cmd_busy), 32'd0);
         check("R1 idle mdc", 32'(mdc), 32'd0);
         check("R1 idle oe", 32'(mdio_oe), 32'd0);
         check("R10 rdata held", 32'(cmd_rdata), 32'(exp_rdata));
      end
   endtask

   task automatic t_reset();
      check("R1 mdc", 32'(mdc), 32'd0);
      check("R1 oe", 32'(mdio_oe), 32'd0);
      check("R1 busy", 32'(cmd_busy), 32'd0);
      check("R1 done", 32'(cmd_done), 32'd0);
      check("R1 rdata", 32'(cmd_rdata), 32'd0);
   endtask

   task automatic t_write_basic();
      run_frame(1'b0, 5'h01, 5'h00, 16'h2100, 8'd2, 16'h0000, -1, "");
      idle_check(3);
   endtask

   task automatic t_read_basic();
      run_frame(1'b1, 5'h01, 5'h01, 16'h0000, 8'd2, 16'hA5C3, -1, "");
      idle_check(3);
   endtask

   task automatic t_quarter_variants();
      run_frame(1'b1, 5'h0A, 5'h15, 16'h0000, 8'd1, 16'h3C96, -1, "");
      idle_check(2);
      run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 8'd3, 16'h0000, -1, "");
      idle_check(2);
      run_frame(1'b1, 5'h12, 5'h04, 16'h0000, 8'd0, 16'h0001, -1, "");
      idle_check(2);
   endtask

   task automatic t_ignore_start();
      run_frame(1'b1, 5'h03, 5'h11, 16'h0000, 8'd2, 16'h8001, 40, "/R9");
      idle_check(2);
      run_frame(1'b0, 5'h05, 5'h0C, 16'h1234, 8'd2, 16'h0000, 50, "/R9");
      idle_check(2);
   endtask

   task automatic t_back_to_back();
      run_frame(1'b1, 5'h01, 5'h05, 16'h0000, 8'd2, 16'h5AA5, -1, "");
      run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 8'd2, 16'h0000, -1, "/R11");
      idle_check(3);
   endtask

   initial begin
      rst_n       = 1'b0;
      cmd_start   = 1'b0;
      cmd_read    = 1'b0;
      cmd_phy     = 5'h00;
      cmd_reg     = 5'h00;
      cmd_wdata   = 16'h0000;
      quarter_len = 8'd2;
      mdio_in     = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_basic();
      t_read_basic();
      t_quarter_variants();
      t_ignore_start();
      t_back_to_back();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule